// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This unit sits next to the shift register of an I2C slave port and decides whether a transfer is meant for this device. It watches the byte strobe from the shift register together with the START, repeated-START and STOP indications. It compares only the first byte received after each START or repeated START. An all-zero first byte is a general call and sets one status flag. A first byte whose upper seven bits equal the programmed own address sets a second, separate flag. Either outcome gives the host CPU a one-cycle interrupt request and raises an ACK-enable level for the acknowledge stage.

The CPU writes an 8-bit address register. The upper seven bits hold the own address and bit 0 is a read/write qualifier. With the qualifier clear, the R/W bit of the received byte is ignored. With the qualifier set, a session opened by a repeated START compares all eight bits. 10-bit addressing is handled with firmware help. The CPU programs the fixed 10-bit prefix as the own address, and the unit matches only the first byte. The second address byte goes untouched to the data path for a software compare. Firmware then sets the qualifier, so that the read header after the repeated START is matched with its R/W bit.

Top module: `i2c_addr_rec`

## Requirements
- R1: After reset the address register reads 0x00, and the general-call flag, the address-match flag, the interrupt request and ACK-enable are all low.
- R2: A CPU write loads all 8 bits of the address register, which reads back the written value from the cycle after the write. Bits 7..1 are the own address and bit 0 is the qualifier.
- R3: If the first byte after START/repeated START is 0x00, the general-call flag is 1 and the match flag is 0 from the cycle after the byte strobe. The general call takes precedence even when the own address is also zero.
- R4: If the first byte is not 0x00 and its bits 7..1 equal register bits 7..1, the match flag is 1 from the cycle after the strobe, provided the full compare of R7 is not in force. Bit 0 of the byte is ignored here.
- R5: If the first byte is neither a general call nor a match, both flags are 0 after the strobe and no interrupt request occurs. The two flags are never 1 together.
- R6: Bytes after the first byte of a session, and bytes outside any session, leave both flags unchanged and raise no interrupt request.
- R7: When register bit 0 is 1 and the session was opened by a repeated START, a match requires all 8 bits of the first byte to equal the register.
- R8: When register bit 0 is 1 and the session was opened by a plain START, only bits 7..1 are compared.
- R9: A STOP, START or repeated START clears both flags in the following cycle. In the same cycle as STOP or an opening condition, a byte strobe is not treated as an address byte.
- R10: The interrupt request is high for exactly one cycle, in the cycle after the strobe of an address byte that gave a general call or a match.
- R11: ACK-enable is high exactly while either flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_we | input | 1 | CPU write strobe for the address register |
| adr_wdata | input | 8 | CPU write data: own address in bits 7..1, qualifier in bit 0 |
| adr_q | output | 8 | Address register contents |
| byte_valid | input | 1 | One-cycle strobe: a received byte is present |
| byte_data | input | 8 | Received byte, R/W in bit 0 |
| start_det | input | 1 | One-cycle START indication |
| rstart_det | input | 1 | One-cycle repeated-START indication |
| stop_det | input | 1 | One-cycle STOP indication |
| ad0_flag | output | 1 | General-call status flag |
| aas_flag | output | 1 | Own-address match status flag |
| irq_req | output | 1 | One-cycle interrupt request |
| ack_en | output | 1 | Permits the ACK stage to acknowledge |

## Verification
The hardest case to reach from the ports is the full 8-bit compare. It needs the qualifier set, a session opened by a repeated START rather than a START, and a first byte that agrees in the upper seven bits but differs in the R/W bit. Random bytes almost never hit it. The stimulus therefore draws the first byte from a biased mix: the exact register value, the own address with a flipped R/W bit, zero, or fully random. It also picks START or repeated START at random. Directed cases cover each qualifier/opening combination and a zero own address.

// File: rtl/i2c_arec_pkg.sv
package i2c_arec_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SA_W   = BYTE_W - 1;

  typedef enum logic [1:0] {
    SES_IDLE = 2'd0,
    SES_ADDR = 2'd1,
    SES_DATA = 2'd2
  } ses_e;

  function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
    return (b == '0);
  endfunction

  function automatic logic own_hit(input logic [BYTE_W-1:0] b,
                                   input logic [BYTE_W-1:0] adr,
                                   input logic              full);
    logic upper_eq;
    upper_eq = (b[BYTE_W-1:1] == adr[BYTE_W-1:1]);
    return full ? (upper_eq && (b[0] == adr[0])) : upper_eq;
  endfunction

endpackage

// File: rtl/arec_ownreg.sv
module arec_ownreg
  import i2c_arec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] own_q,
  output logic              rbw_q
);
  logic [BYTE_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  reg_q <= RESET_VAL;
    else if (we) reg_q <= wdata;
  end

  assign own_q = reg_q;
  assign rbw_q = reg_q[0];
endmodule

// File: rtl/arec_session.sv
module arec_session
  import i2c_arec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic rstart_det,
  input  logic stop_det,
  input  logic byte_valid,
  output logic open_evt,
  output logic close_evt,
  output logic addr_evt,
  output logic rs_session
);
  ses_e state_q, state_d;
  logic rs_q, rs_d;

  assign open_evt  = start_det | rstart_det;
  assign close_evt = stop_det;
  assign addr_evt  = byte_valid && (state_q == SES_ADDR) && !open_evt && !close_evt;

  always_comb begin
    state_d = state_q;
    rs_d    = rs_q;
    if (close_evt) begin
      state_d = SES_IDLE;
      rs_d    = 1'b0;
    end else if (open_evt) begin
      state_d = SES_ADDR;
      rs_d    = rstart_det;
    end else if (addr_evt) begin
      state_d = SES_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SES_IDLE;
      rs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rs_q    <= rs_d;
    end
  end

  assign rs_session = rs_q;
endmodule

// File: rtl/arec_compare.sv
module arec_compare
  import i2c_arec_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] own_adr,
  input  logic              rbw,
  input  logic              rs_session,
  output logic              gcall,
  output logic              hit,
  output logic              full_cmp
);
  assign full_cmp = rbw & rs_session;
  assign gcall    = is_gcall(rx_byte);
  assign hit      = !gcall && own_hit(rx_byte, own_adr, full_cmp);
endmodule

// File: rtl/arec_flags.sv
module arec_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic gcall,
  input  logic hit,
  output logic ad0_q,
  output logic aas_q,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad0_q <= 1'b0;
      aas_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= load & (gcall | hit);
      if (clr) begin
        ad0_q <= 1'b0;
        aas_q <= 1'b0;
      end else if (load) begin
        ad0_q <= gcall;
        aas_q <= hit;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_rec.sv
module i2c_addr_rec
  import i2c_arec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_we,
  input  logic [BYTE_W-1:0] adr_wdata,
  output logic [BYTE_W-1:0] adr_q,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              start_det,
  input  logic              rstart_det,
  input  logic              stop_det,
  output logic              ad0_flag,
  output logic              aas_flag,
  output logic              irq_req,
  output logic              ack_en
);
  logic rbw;
  logic open_evt, close_evt, addr_evt, rs_session;
  logic gcall, hit, full_cmp;

  arec_ownreg #(.RESET_VAL(RESET_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(adr_we), .wdata(adr_wdata),
    .own_q(adr_q), .rbw_q(rbw)
  );

  arec_session u_ses (
    .clk(clk), .rst_n(rst_n),
    .start_det(start_det), .rstart_det(rstart_det), .stop_det(stop_det),
    .byte_valid(byte_valid),
    .open_evt(open_evt), .close_evt(close_evt), .addr_evt(addr_evt),
    .rs_session(rs_session)
  );

  arec_compare u_cmp (
    .rx_byte(byte_data), .own_adr(adr_q), .rbw(rbw), .rs_session(rs_session),
    .gcall(gcall), .hit(hit), .full_cmp(full_cmp)
  );

  arec_flags u_flg (
    .clk(clk), .rst_n(rst_n),
    .clr(open_evt | close_evt), .load(addr_evt),
    .gcall(gcall), .hit(hit),
    .ad0_q(ad0_flag), .aas_q(aas_flag), .irq_q(irq_req)
  );

  assign ack_en = ad0_flag | aas_flag;
endmodule

// File: rtl/i2c_addr_rec_chk.sv
module i2c_addr_rec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adr_we,
  input logic [7:0] adr_wdata,
  input logic [7:0] adr_q,
  input logic [7:0] byte_data,
  input logic       stop_det,
  input logic       open_evt,
  input logic       addr_evt,
  input logic       full_cmp,
  input logic       ad0_flag,
  input logic       aas_flag,
  input logic       irq_req,
  input logic       ack_en
);
  a_r2_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
    adr_we |=> adr_q == $past(adr_wdata));

  a_r3_gcall: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_evt && byte_data == 8'h00) |=> (ad0_flag && !aas_flag && irq_req));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad0_flag && aas_flag));

  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_evt |=> !irq_req);

  a_r7_full_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_evt && full_cmp && byte_data[0] != adr_q[0]) |=> !aas_flag);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!ad0_flag && !aas_flag));

  a_r9_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> (!ad0_flag && !aas_flag));

  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  a_r11_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ack_en);
endmodule

bind i2c_addr_rec i2c_addr_rec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adr_we(adr_we), .adr_wdata(adr_wdata),
  .adr_q(adr_q), .byte_data(byte_data), .stop_det(stop_det),
  .open_evt(open_evt), .addr_evt(addr_evt), .full_cmp(full_cmp),
  .ad0_flag(ad0_flag), .aas_flag(aas_flag), .irq_req(irq_req), .ack_en(ack_en)
);

// File: tb/sim_i2c_addr_rec.sv
`timescale 1ns/1ps
module sim_i2c_addr_rec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       adr_we = 0;
  logic [7:0] adr_wdata = 0;
  logic [7:0] adr_q;
  logic       byte_valid = 0;
  logic [7:0] byte_data = 0;
  logic       start_det = 0, rstart_det = 0, stop_det = 0;
  logic       ad0_flag, aas_flag, irq_req, ack_en;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  logic [7:0] m_reg = 0;
  bit  m_rs = 0;

  always #2 clk = ~clk;

  i2c_addr_rec u0 (
    .clk(clk), .rst_n(rst_n), .adr_we(adr_we), .adr_wdata(adr_wdata), .adr_q(adr_q),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .start_det(start_det), .rstart_det(rstart_det), .stop_det(stop_det),
    .ad0_flag(ad0_flag), .aas_flag(aas_flag), .irq_req(irq_req), .ack_en(ack_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_gc(input logic [7:0] b);
    return b == 8'h00;
  endfunction

  function automatic bit exp_hit(input logic [7:0] b, input logic [7:0] r, input bit rs);
    if (b == 8'h00) return 0;
    if (r[0] && rs) return b == r;
    return (b >> 1) == (r >> 1);
  endfunction

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); adr_we = 1; adr_wdata = v;
    @(posedge clk); #1;
    check("R2 readback", adr_q, v);
    m_reg = v;
    @(negedge clk); adr_we = 0;
  endtask

  task automatic open_sess(input bit rs);
    @(negedge clk); start_det = !rs; rstart_det = rs;
    @(posedge clk); #1;
    check("R9 open clears", {ad0_flag, aas_flag, ack_en}, 3'b000);
    m_rs = rs;
    @(negedge clk); start_det = 0; rstart_det = 0;
  endtask

  task automatic close_sess();
    @(negedge clk); stop_det = 1;
    @(posedge clk); #1;
    check("R9 stop clears", {ad0_flag, aas_flag, ack_en}, 3'b000);
    @(negedge clk); stop_det = 0;
  endtask

  task automatic send_addr(input logic [7:0] b);
    bit g, h;
    g = exp_gc(b);
    h = exp_hit(b, m_reg, m_rs);
    @(negedge clk); byte_valid = 1; byte_data = b;
    @(posedge clk); #1;
    check("R3 general-call flag", ad0_flag, g);
    check("R4/R7/R8 match flag", aas_flag, h);
    check("R5/R10 irq pulse", irq_req, g | h);
    check("R11 ack_en", ack_en, g | h);
    @(negedge clk); byte_valid = 0;
    @(posedge clk); #1;
    check("R10 irq single cycle", irq_req, 1'b0);
    check("R3/R4 flags held", {ad0_flag, aas_flag}, {g, h});
  endtask

  task automatic send_data(input logic [7:0] b);
    logic [1:0] prev;
    prev = {ad0_flag, aas_flag};
    @(negedge clk); byte_valid = 1; byte_data = b;
    @(posedge clk); #1;
    check("R6 later byte ignored", {ad0_flag, aas_flag, irq_req}, {prev, 1'b0});
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0;
    #1;
    check("R1 reset outputs", {adr_q, ad0_flag, aas_flag, irq_req, ack_en}, 12'h000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 after reset", {adr_q, ad0_flag, aas_flag, irq_req, ack_en}, 12'h000);

    // R6: byte with no session open
    send_data(8'h00);

    // R3 general call with own address zero
    open_sess(0); send_addr(8'h00); close_sess();

    write_reg(8'hA4);
    open_sess(0); send_addr(8'hA5); send_data(8'h00); send_data(8'hA4); close_sess(); // R4, R6
    open_sess(0); send_addr(8'h3C); close_sess();                                       // R5
    open_sess(0); send_addr(8'h00); send_data(8'hA4); close_sess();                     // R3, R6

    write_reg(8'hA5);                                                                   // qualifier set
    open_sess(1); send_addr(8'hA4); close_sess();                                       // R7 rw mismatch
    open_sess(1); send_addr(8'hA5);                                                     // R7 exact
    open_sess(0); send_addr(8'hA4); close_sess();                                       // R8, R9 restart clears

    // R9: strobe in same cycle as STOP is not an address byte
    open_sess(0);
    @(negedge clk); byte_valid = 1; byte_data = 8'hA5; stop_det = 1;
    @(posedge clk); #1;
    check("R9 strobe with stop", {ad0_flag, aas_flag, irq_req}, 3'b000);
    @(negedge clk); byte_valid = 0; stop_det = 0;

    for (int i = 0; i < 300; i++) begin
      logic [7:0] b;
      int sel;
      if ($urandom % 5 == 0) write_reg(8'($urandom));
      open_sess(bit'($urandom % 2));
      sel = $urandom % 4;
      case (sel)
        0: b = 8'h00;
        1: b = {m_reg[7:1], ~m_reg[0]};
        2: b = m_reg;
        default: b = 8'($urandom);
      endcase
      send_addr(b);
      for (int k = 0; k < int'($urandom % 3); k++) send_data(8'($urandom));
      if ($urandom % 2 == 0) close_sess();
    end

    done = 1;
    finish_run();
  end
endmodule